// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one N-bit integer by another over several clock cycles, one quotient bit per cycle, using the restoring shift-and-subtract method. A single shared register holds both results. Its upper part collects the partial remainder, and its lower part starts with the dividend and is refilled from the right with quotient bits. One subtractor of N+1 bits works only on the upper part.

A caller presents the operands with a one-cycle `start` pulse while the divider is idle. `busy` then stays high for N+1 cycles: N iteration cycles and one correction cycle. On the cycle `busy` falls, `done` pulses for one cycle and the quotient, remainder and divide-by-zero flag appear. These outputs hold until the next operation completes.

With `is_signed` set, the block records the operand signs and divides the magnitudes. It then sets the result signs so that the quotient truncates toward zero and the remainder carries the sign of the dividend. A zero divisor is reported through a flag and a fixed result pattern, and the operation takes the same number of cycles as any other.

Top module: `restoring_div`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: A `start` seen at a rising edge while `busy` is low is accepted. `busy` is high for exactly N+1 cycles after the accepting edge. `done` is high for exactly one cycle, beginning at the edge where `busy` falls. `busy` and `done` are never high together. A `start` during the `done` cycle is accepted.
- R3: A `start` or an operand change while `busy` is high, including in the last busy cycle, has no effect on the result or on the timing of the running operation.
- R4: With `is_signed`=0, `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor. This includes divisors with the top bit set, divisor equal to dividend, and dividend smaller than divisor. For 7/2 the quotient is 3 and the remainder is 1.
- R5: With `is_signed`=1, operands are two's complement. The quotient magnitude is |dividend|/|divisor| truncated, and the quotient is negated exactly when the operand signs differ (7/-2 gives -3).
- R6: With `is_signed`=1, the remainder is zero or takes the dividend's sign: -7/2 gives quotient -3 and remainder -1, and -7/-2 gives 3 and -1.
- R7: A zero divisor sets `div_by_zero`, makes `quotient` all ones and `remainder` equal to the raw dividend, in either mode, with the same N+1 cycle timing. In every other case `div_by_zero` is 0.
- R8: Signed division of the most negative value by -1 gives the low N bits of the true quotient, the bit pattern 1 followed by N-1 zeros, with remainder 0.
- R9: `quotient`, `remainder` and `div_by_zero` change only at the edge that raises `done`, and hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; honoured only while `busy` is low |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | WIDTH | Dividend, sampled with an accepted `start` |
| divisor | input | WIDTH | Divisor, sampled with an accepted `start` |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when results become valid |
| quotient | output | WIDTH | Quotient of the last completed operation |
| remainder | output | WIDTH | Remainder of the last completed operation |
| div_by_zero | output | 1 | The last completed operation had a zero divisor |

## Verification
Two events can coincide here. The completion pulse of one operation can share a cycle with the acceptance of the next `start`, and a stray `start` can arrive in the final correction cycle, when the block is still busy but about to go idle. The bench provokes both: it issues every new operation in the `done` cycle of the previous one, and it injects stray starts with different operands at several points of a run, including the correction cycle. A cycle-accurate model in the bench predicts `busy`, `done` and the held results on every clock. It must agree that the back-to-back start is taken and the stray one is not.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  div_state_e    state;
  logic [CW-1:0] cnt;

  assign busy   = (state != ST_IDLE);
  assign load   = (state == ST_IDLE) && start;
  assign step   = (state == ST_RUN);
  assign finish = (state == ST_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: completion pulse lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: handshake outputs are mutually exclusive
  a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R2: done only follows the correction cycle
  a_r2_done_after_fix: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(finish));
  // R3: a running count is never restarted, whatever start does
  a_r3_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != LAST) |=> (step && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] num_mag,
  input  logic [WIDTH-1:0] den_mag,
  output logic [WIDTH-1:0] quo_mag,
  output logic [WIDTH-1:0] rem_mag
);
  localparam int AW = 2 * WIDTH + 1;

  logic [AW-1:0]    acc;
  logic [WIDTH-1:0] den_q;
  logic [WIDTH+1:0] trial;
  logic             trial_fits;

  function automatic logic [WIDTH+1:0] try_sub(input logic [WIDTH:0] hi,
                                               input logic [WIDTH-1:0] d);
    return {1'b0, hi} - {2'b00, d};
  endfunction

  function automatic logic [WIDTH-1:0] undo_overshift(input logic [WIDTH:0] hi);
    return hi[WIDTH:1];
  endfunction

  assign trial      = try_sub(acc[AW-1:WIDTH], den_q);
  assign trial_fits = ~trial[WIDTH+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      den_q <= '0;
    end else if (load) begin
      acc   <= {{WIDTH{1'b0}}, num_mag, 1'b0};
      den_q <= den_mag;
    end else if (step) begin
      if (trial_fits) acc <= {trial[WIDTH-1:0], acc[WIDTH-1:0], 1'b1};
      else            acc <= {acc[AW-2:0], 1'b0};
    end
  end

  assign quo_mag = acc[WIDTH-1:0];
  assign rem_mag = undo_overshift(acc[AW-1:WIDTH]);

  // R4: a successful trial difference always fits in WIDTH bits
  a_r4_trial_width: assert property (@(posedge clk) disable iff (!rst_n)
    (step && trial_fits) |-> !trial[WIDTH]);
  // R4: after each step the partial remainder stays below the divisor
  a_r4_partial_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    (step && den_q != '0) |=> (acc[AW-1:WIDTH+1] < den_q));
endmodule

// File: rtl/restoring_div.sv
module restoring_div #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);
  logic             load, step, finish;
  logic             num_neg, den_neg;
  logic [WIDTH-1:0] num_mag, den_mag, quo_mag, rem_mag;
  logic             neg_quo_q, neg_rem_q, zero_den_q;
  logic [WIDTH-1:0] raw_num_q;

  function automatic logic [WIDTH-1:0] to_mag(input logic [WIDTH-1:0] v,
                                              input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  assign num_neg = is_signed & dividend[WIDTH-1];
  assign den_neg = is_signed & divisor[WIDTH-1];
  assign num_mag = to_mag(dividend, num_neg);
  assign den_mag = to_mag(divisor, den_neg);

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load), .step(step),
    .finish(finish), .busy(busy), .done(done)
  );

  div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .num_mag(num_mag), .den_mag(den_mag), .quo_mag(quo_mag), .rem_mag(rem_mag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_quo_q   <= 1'b0;
      neg_rem_q   <= 1'b0;
      zero_den_q  <= 1'b0;
      raw_num_q   <= '0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      if (load) begin
        neg_quo_q  <= num_neg ^ den_neg;
        neg_rem_q  <= num_neg;
        zero_den_q <= (divisor == '0);
        raw_num_q  <= dividend;
      end
      if (finish) begin
        div_by_zero <= zero_den_q;
        if (zero_den_q) begin
          quotient  <= '1;
          remainder <= raw_num_q;
        end else begin
          quotient  <= to_mag(quo_mag, neg_quo_q);
          remainder <= to_mag(rem_mag, neg_rem_q);
        end
      end
    end
  end

  // R6: a non-zero remainder of a negative dividend is negative
  a_r6_rem_follows_dividend: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero && neg_rem_q && remainder != '0) |-> remainder[WIDTH-1]);
  // R9: results move only on the edge that raises done
  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

// File: tb/sim_restoring_div.sv
`timescale 1ns/1ps
module sim_restoring_div;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  restoring_div #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input bit s, output logic [W-1:0] q,
                                  output logic [W-1:0] r, output bit z);
    int ia, ib, iq, ir;
    if (b == '0) begin
      q = '1; r = a; z = 1'b1;
      return;
    end
    ia = (s && a[W-1]) ? int'(a) - (1 << W) : int'(a);
    ib = (s && b[W-1]) ? int'(b) - (1 << W) : int'(b);
    iq = ia / ib;
    ir = ia % ib;
    q = iq[W-1:0]; r = ir[W-1:0]; z = 1'b0;
  endfunction

  // Behavioural model of the handshake and the held results
  bit         m_busy, m_done, m_z, p_z;
  int         m_left;
  logic [W-1:0] m_q, m_r, p_q, p_r;
  string      p_tag, m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0;
      m_q = '0; m_r = '0; m_z = 0; m_tag = "R1";
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_left == 1) begin
          m_busy = 0; m_done = 1;
          m_q = p_q; m_r = p_r; m_z = p_z; m_tag = p_tag;
        end
        m_left = m_left - 1;
      end else if (start) begin
        m_busy = 1;
        m_left = W + 1;
        ref_div(dividend, divisor, is_signed, p_q, p_r, p_z);
        if (divisor == '0) p_tag = "R7";
        else if (is_signed && dividend == 8'h80 && divisor == 8'hFF) p_tag = "R8";
        else if (is_signed) p_tag = "R5/R6";
        else p_tag = "R4";
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        check(busy == 0 && done == 0, "R1 handshake", {busy, done}, 0);
        check(quotient == 0 && remainder == 0 && div_by_zero == 0, "R1 results",
              int'(quotient), 0);
      end else begin
        check(busy == m_busy, "R2/R3 busy", busy, m_busy);
        check(done == m_done, "R2/R3 done", done, m_done);
        check(quotient == m_q, m_done ? {m_tag, " quotient"} : "R9 quotient held",
              int'(quotient), int'(m_q));
        check(remainder == m_r, m_done ? {m_tag, " remainder"} : "R9 remainder held",
              int'(remainder), int'(m_r));
        check(div_by_zero == m_z, m_done ? "R7 flag" : "R9 flag held",
              div_by_zero, m_z);
      end
    end
  end

  // Runs one operation; a stray start with other operands goes in at edge k (0: none)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                        input int k, input logic [W-1:0] a2, input logic [W-1:0] b2);
    start = 1; dividend = a; divisor = b; is_signed = s;
    @(negedge clk);
    for (int i = 1; i <= W + 1; i++) begin
      if (i == k) begin
        start = 1; dividend = a2; divisor = b2; is_signed = ~s;
      end else begin
        start = 0;
      end
      @(negedge clk);
    end
    start = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [W-1:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run_op(8'd7,   8'd2,   0, 0, 0, 0);         // R4 7/2
    run_op(8'hF9,  8'd2,   1, 0, 0, 0);         // R6 -7/2
    run_op(8'd7,   8'hFE,  1, 0, 0, 0);         // R5 7/-2
    run_op(8'hF9,  8'hFE,  1, 0, 0, 0);         // R6 -7/-2
    run_op(8'd250, 8'd128, 0, 0, 0, 0);         // R4 divisor top bit set
    run_op(8'd200, 8'd201, 0, 0, 0, 0);         // R4 dividend below divisor
    run_op(8'd255, 8'd255, 0, 0, 0, 0);         // R4 equal operands
    run_op(8'd255, 8'd1,   0, 0, 0, 0);         // R4 unit divisor
    run_op(8'h80,  8'hFF,  1, 0, 0, 0);         // R8 overflow case
    run_op(8'd37,  8'd0,   0, 0, 0, 0);         // R7 unsigned
    run_op(8'hFB,  8'd0,   1, 0, 0, 0);         // R7 signed
    run_op(8'd100, 8'd7,   0, 3, 8'd9, 8'd0);   // R3 stray start mid-run
    run_op(8'h9C,  8'd7,   1, W + 1, 8'd1, 8'd3); // R3 stray start in last busy cycle
    run_op(8'd13,  8'd5,   0, 1, 8'd0, 8'd0);   // R3 stray start right after accept
    lf = 8'hA5;
    for (int n = 0; n < 24; n++) begin
      logic [W-1:0] x, y;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      x = lf;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      y = (n % 7 == 6) ? 8'd0 : lf;
      run_op(x, y, n[0], 0, 0, 0);              // R4/R5/R6 mixed patterns
    end
    repeat (5) @(negedge clk);                  // R9 idle hold
    finish_run();
  end
endmodule